// File: doc/BRIEF.md
# Double-Buffered Clock Register Front End

This block is the byte-wide, memory-mapped front end of a timekeeping core. It decodes a chip-select / output-enable / write-enable strobe set, all sampled on a system clock, and serves the eight highest byte addresses of a RAM address space from its own register file. Addresses below that window go to an external RAM through read and write enables. The register file holds a user-visible copy of the time, apart from the live counters. The live counters sit outside this block and never stop.

The copy is refreshed from the live counters on each one-second tick while both halt bits in the control byte are clear. Setting the read-halt bit freezes the copy so software can read a consistent snapshot. Setting the write-halt bit lets software load new time values. Clearing it sends a single-cycle load strobe, carrying those values, toward the counter block. The register file also carries an oscillator stop bit, a frequency-test bit that replaces the seconds LSB on read with a 512 Hz square wave, a read-only battery flag, and spare bits that act as RAM. While the power-fail input is high, every access is blocked and an active-low reset output is driven.

Top module: `rtc_shadow_regs`

## Requirements
- R1: The top eight addresses map to offsets 0..7 (offset = address minus 2^ADDR_W-8) in this order: control/century, seconds, minutes, hours, weekday, day of month, month, year. A byte written there reads back unchanged, spare bits included, except where R8 to R10 say otherwise.
- R2: `dqOe` is 1 exactly when `ceN`=0, `oeN`=0, `weN`=1 and `pwrFail`=0. In every other case it is 0.
- R3: A cycle with `ceN`=0, `weN`=0 and `pwrFail`=0 stores `dqIn` into the addressed window byte at that rising edge.
- R4: On a cycle with `secTick`=1 while control bit 6 (read halt) and bit 7 (write halt) are both 0, the field bits of every byte take the matching bits of `liveTime` (byte i at bits 8i+7..8i). The field masks for offsets 0..7 are 3F,7F,7F,3F,07,3F,1F,FF hex. All other bits keep their value.
- R5: While control bit 6 is 1, `secTick` leaves the user copy unchanged.
- R6: While control bit 7 is 1, no refresh occurs. When the bit goes from 1 to 0, `loadStrobe` is 1 for exactly the next cycle, with `loadTime` byte i equal to user byte i ANDed with its field mask.
- R7: When a window write and a refresh fall in the same cycle, the written byte takes the bus data and every other byte is refreshed.
- R8: `oscStop` equals bit 7 of the seconds byte.
- R9: When weekday bit 6 is 1 and seconds bit 7 is 0, a read of the seconds byte returns, in bit 0, a square wave. It starts at 0 after reset and toggles after every 32 `oscTick` pulses. Otherwise bit 0 reads as stored.
- R10: Weekday bit 7 always reads as `battGood`, and writes to it have no effect.
- R11: While `pwrFail` is 1, no register or RAM byte is written, `dqOe`, `ramRdEn` and `ramWrEn` are 0, and `rstOutN` is 0. Otherwise `rstOutN` is 1.
- R12: Outside the window, a read access raises `ramRdEn` and `dqOut` carries `ramRdData`, and a write access raises `ramWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dqIn | input | 8 | Write data |
| dqOut | output | 8 | Read data |
| dqOe | output | 1 | Read data drive enable |
| pwrFail | input | 1 | Supply out of tolerance; blocks access |
| rstOutN | output | 1 | Active-low reset while power fails |
| ramRdEn | output | 1 | Read enable to external RAM |
| ramWrEn | output | 1 | Write enable to external RAM |
| ramRdData | input | 8 | Read data from external RAM |
| liveTime | input | 64 | Live counter fields, byte i = offset i |
| secTick | input | 1 | One-cycle pulse once per second |
| oscTick | input | 1 | One-cycle pulse at 32.768 kHz |
| battGood | input | 1 | Battery level good |
| loadStrobe | output | 1 | One-cycle load request to counters |
| loadTime | output | 64 | Time fields to load, byte i = offset i |
| oscStop | output | 1 | Oscillator stop request |

## Verification
The one-second refresh and a bus write can hit the same register on the same edge. The bench provokes this by raising `secTick` in the cycle that writes the minutes byte, with a `liveTime` that differs from the bus data. It then reads the written byte, which must hold the bus value, and the neighbouring bytes, which must hold the live fields. A second overlap, a read of the seconds byte that spans frequency-test toggles, is judged on every clock against a behavioural model.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // register offsets inside the window
  localparam int OFF_CTRL = 0;
  localparam int OFF_SEC  = 1;
  localparam int OFF_DAY  = 4;

  // bit positions
  localparam int BIT_WHALT = 7;
  localparam int BIT_RHALT = 6;
  localparam int BIT_OSC   = 7;
  localparam int BIT_FT    = 6;
  localparam int BIT_BATT  = 7;

  typedef struct packed {
    logic             regRd;
    logic             regWr;
    logic             ramRd;
    logic             ramWr;
    logic [IDX_W-1:0] idx;
    logic             refresh;
    logic             load;
  } strobe_t;

  // time-field bits of each register; the rest are control or spare bits
  function automatic logic [7:0] fieldMask(int idx);
    case (idx)
      0:       return 8'h3F;
      1:       return 8'h7F;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwrFail,
  input  logic              secTick,
  input  logic              rdHalt,
  input  logic              wrHalt,
  output strobe_t           stb,
  output logic              dqOe,
  output logic              rstOutN
);

  logic rdAcc;
  logic wrAcc;
  logic inWin;
  logic wPrev;

  always_comb begin
    rdAcc = !ceN && !oeN && weN && !pwrFail;
    wrAcc = !ceN && !weN && !pwrFail;
    inWin = &addr[ADDR_W-1:IDX_W];
  end

  // remembers the write-halt bit to find its falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wPrev <= 1'b0;
    else       wPrev <= wrHalt;
  end

  always_comb begin
    stb.regRd   = rdAcc && inWin;
    stb.regWr   = wrAcc && inWin;
    stb.ramRd   = rdAcc && !inWin;
    stb.ramWr   = wrAcc && !inWin;
    stb.idx     = addr[IDX_W-1:0];
    stb.refresh = secTick && !rdHalt && !wrHalt;
    stb.load    = wPrev && !wrHalt;
  end

  always_comb begin
    dqOe    = rdAcc;
    rstOutN = !pwrFail;
  end

endmodule

// File: rtl/rtc_shadow_dp.sv
module rtc_shadow_dp
  import rtc_shadow_pkg::*;
#(
  parameter int OSC_DIV = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [7:0]            wrData,
  input  logic [NUM_REGS*8-1:0] liveTime,
  input  logic                  oscTick,
  input  logic                  battGood,
  input  logic [7:0]            ramRdData,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] loadTime,
  output logic                  rdHalt,
  output logic                  wrHalt,
  output logic                  oscStop
);

  localparam int HALF  = OSC_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);

  logic [7:0]       userReg [NUM_REGS];
  logic [CNT_W-1:0] divCnt;
  logic             ftWave;
  logic [7:0]       regByte;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] MASK  = fieldMask(i);
    localparam logic [7:0] WMASK = (i == OFF_DAY) ? ~(8'd1 << BIT_BATT) : 8'hFF;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        userReg[i] <= '0;
      end else if (stb.regWr && stb.idx == IDX_W'(i)) begin
        userReg[i] <= wrData & WMASK;
      end else if (stb.refresh) begin
        userReg[i] <= (userReg[i] & ~MASK) | (liveTime[8*i +: 8] & MASK);
      end
    end

    assign loadTime[8*i +: 8] = userReg[i] & MASK;
  end

  // frequency-test square wave from the oscillator tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      ftWave <= 1'b0;
    end else if (oscTick) begin
      if (divCnt == HALF_LAST) begin
        divCnt <= '0;
        ftWave <= !ftWave;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    rdHalt  = userReg[OFF_CTRL][BIT_RHALT];
    wrHalt  = userReg[OFF_CTRL][BIT_WHALT];
    oscStop = userReg[OFF_SEC][BIT_OSC];
  end

  always_comb begin
    regByte = userReg[stb.idx];
    if (stb.idx == IDX_W'(OFF_DAY)) regByte[BIT_BATT] = battGood;
    if (stb.idx == IDX_W'(OFF_SEC) && userReg[OFF_DAY][BIT_FT] && !oscStop)
      regByte[0] = ftWave;
    rdData = stb.regRd ? regByte : ramRdData;
  end

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int OSC_DIV = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dqIn,
  output logic [7:0]        dqOut,
  output logic              dqOe,
  input  logic              pwrFail,
  output logic              rstOutN,
  output logic              ramRdEn,
  output logic              ramWrEn,
  input  logic [7:0]        ramRdData,
  input  logic [63:0]       liveTime,
  input  logic              secTick,
  input  logic              oscTick,
  input  logic              battGood,
  output logic              loadStrobe,
  output logic [63:0]       loadTime,
  output logic              oscStop
);

  strobe_t stb;
  logic    rdHalt;
  logic    wrHalt;

  rtc_shadow_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .addr    (addr),
    .pwrFail (pwrFail),
    .secTick (secTick),
    .rdHalt  (rdHalt),
    .wrHalt  (wrHalt),
    .stb     (stb),
    .dqOe    (dqOe),
    .rstOutN (rstOutN)
  );

  rtc_shadow_dp #(.OSC_DIV(OSC_DIV)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (dqIn),
    .liveTime  (liveTime),
    .oscTick   (oscTick),
    .battGood  (battGood),
    .ramRdData (ramRdData),
    .rdData    (dqOut),
    .loadTime  (loadTime),
    .rdHalt    (rdHalt),
    .wrHalt    (wrHalt),
    .oscStop   (oscStop)
  );

  assign ramRdEn    = stb.ramRd;
  assign ramWrEn    = stb.ramWr;
  assign loadStrobe = stb.load;

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic              pwrFail,
  input logic              dqOe,
  input logic              ramRdEn,
  input logic              ramWrEn,
  input logic              rstOutN,
  input logic              loadStrobe,
  input logic [63:0]       loadTime,
  input logic              oscStop,
  input logic              rdHalt
);

  logic anyWr;
  logic winWr;
  logic ctrlWr;
  logic secWr;

  always_comb begin
    anyWr  = !ceN && !weN && !pwrFail;
    winWr  = anyWr && (&addr[ADDR_W-1:3]);
    ctrlWr = winWr && addr[2:0] == 3'd0;
    secWr  = winWr && addr[2:0] == 3'd1;
  end

  AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!ceN && !oeN && weN)); // R2

  AST_PWR_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> (!dqOe && !ramWrEn && !ramRdEn && !rstOutN)); // R11

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe); // R6

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $past(ctrlWr)); // R6

  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !secWr |=> $stable(oscStop)); // R8

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (rdHalt && !winWr) |=> $stable(loadTime)); // R5

  AST_RAM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRdEn && ramWrEn)); // R12

  AST_RAM_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn || ramWrEn) |-> !(&addr[ADDR_W-1:3])); // R12

endmodule

bind rtc_shadow_regs rtc_shadow_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .ceN        (ceN),
  .oeN        (oeN),
  .weN        (weN),
  .addr       (addr),
  .pwrFail    (pwrFail),
  .dqOe       (dqOe),
  .ramRdEn    (ramRdEn),
  .ramWrEn    (ramWrEn),
  .rstOutN    (rstOutN),
  .loadStrobe (loadStrobe),
  .loadTime   (loadTime),
  .oscStop    (oscStop),
  .rdHalt     (rdHalt)
);

// File: tb/rtc_shadow_regs_tb.sv
module rtc_shadow_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int BASE = (1 << AW) - 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dqIn = '0;
  logic [7:0]    dqOut;
  logic          dqOe;
  logic          pwrFail = 1'b0;
  logic          rstOutN, ramRdEn, ramWrEn;
  logic [7:0]    ramRdData = 8'h3C;
  logic [63:0]   liveTime = '0;
  logic          secTick = 1'b0, oscTick = 1'b0, battGood = 1'b1;
  logic          loadStrobe;
  logic [63:0]   loadTime;
  logic          oscStop;

  int    total = 0;
  int    bad = 0;
  int    strobes = 0;
  bit    done = 0;
  string phase = "R1";

  // behavioural reference state
  logic [7:0] mReg [8];
  int         mCnt;
  bit         mTog;
  bit         mPrevW;
  logic [7:0] masks [8] = '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  rtc_shadow_regs dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .pwrFail(pwrFail),
    .rstOutN(rstOutN), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn),
    .ramRdData(ramRdData), .liveTime(liveTime), .secTick(secTick),
    .oscTick(oscTick), .battGood(battGood), .loadStrobe(loadStrobe),
    .loadTime(loadTime), .oscStop(oscStop)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit inWindow();
    return int'(addr) >= BASE;
  endfunction

  // model update on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mReg[i] = '0;
      mCnt = 0; mTog = 0; mPrevW = 0;
    end else begin
      bit wr, refr;
      int idx;
      wr   = !ceN && !weN && !pwrFail && inWindow();
      idx  = int'(addr) - BASE;
      refr = secTick && !mReg[0][6] && !mReg[0][7];
      mPrevW = mReg[0][7];
      for (int i = 0; i < 8; i++) begin
        if (wr && idx == i) mReg[i] = (i == 4) ? (dqIn & 8'h7F) : dqIn;
        else if (refr) mReg[i] = (mReg[i] & ~masks[i]) | (liveTime[8*i +: 8] & masks[i]);
      end
      if (oscTick) begin
        if (mCnt == 31) begin mCnt = 0; mTog = !mTog; end
        else mCnt++;
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit pOe, pRamRd, pRamWr, pLoad;
      logic [7:0]  pData;
      logic [63:0] pLt;
      pOe    = !ceN && !oeN && weN && !pwrFail;
      pRamRd = pOe && !inWindow();
      pRamWr = !ceN && !weN && !pwrFail && !inWindow();
      if (inWindow()) begin
        int idx;
        idx = int'(addr) - BASE;
        pData = mReg[idx];
        if (idx == 4) pData[7] = battGood;
        if (idx == 1 && mReg[4][6] && !mReg[1][7]) pData[0] = mTog;
      end else begin
        pData = ramRdData;
      end
      pLoad = mPrevW && !mReg[0][7];
      for (int i = 0; i < 8; i++) pLt[8*i +: 8] = mReg[i] & masks[i];
      chk(dqOe == pOe, "R2 dqOe", 64'(dqOe), 64'(pOe));
      chk(rstOutN == !pwrFail, "R11 rstOutN", 64'(rstOutN), 64'(!pwrFail));
      chk(ramRdEn == pRamRd && ramWrEn == pRamWr, "R12 ram enables",
          {ramRdEn, ramWrEn}, {pRamRd, pRamWr});
      if (pOe) chk(dqOut == pData, {phase, " dqOut"}, 64'(dqOut), 64'(pData));
      chk(loadStrobe == pLoad, "R6 loadStrobe", 64'(loadStrobe), 64'(pLoad));
      if (pLoad) chk(loadTime == pLt, "R6 loadTime", loadTime, pLt);
      chk(oscStop == mReg[1][7], "R8 oscStop", 64'(oscStop), 64'(mReg[1][7]));
      if (loadStrobe) strobes++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle();
    ceN = 1; oeN = 1; weN = 1;
  endtask

  task automatic wrByte(int a, logic [7:0] d);
    ceN = 0; weN = 0; oeN = 1; addr = AW'(a); dqIn = d;
    tick();
    idle();
  endtask

  // read with an explicit expected value, checked half a cycle later
  task automatic rdExpect(int a, logic [7:0] exp, string tag);
    ceN = 0; oeN = 0; weN = 1; addr = AW'(a);
    #(CLK_PERIOD/4);
    chk(dqOut == exp && dqOe, tag, 64'(dqOut), 64'(exp));
    tick();
    idle();
  endtask

  task automatic pulseSec();
    secTick = 1;
    tick();
    secTick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) tick();
    rstN = 1;
    tick();
    // reset state
    chk(!dqOe && !loadStrobe && rstOutN && !oscStop, "R11 reset state",
        {dqOe, loadStrobe, rstOutN, oscStop}, 64'h2);

    // R1 R3: fill and read back
    phase = "R1";
    wrByte(BASE + 0, 8'h25); wrByte(BASE + 1, 8'h59);
    wrByte(BASE + 2, 8'hC5); wrByte(BASE + 3, 8'hE3);
    wrByte(BASE + 4, 8'h3B); wrByte(BASE + 5, 8'hC9);
    wrByte(BASE + 6, 8'hF2); wrByte(BASE + 7, 8'h99);
    rdExpect(BASE + 2, 8'hC5, "R3 minutes readback");
    rdExpect(BASE + 6, 8'hF2, "R1 month spare bits");
    rdExpect(BASE + 7, 8'h99, "R1 year");

    // R10 battery flag
    phase = "R10";
    wrByte(BASE + 4, 8'hBB);
    rdExpect(BASE + 4, 8'hBB, "R10 battery good");
    battGood = 0;
    rdExpect(BASE + 4, 8'h3B, "R10 battery low");
    battGood = 1;

    // R4 refresh
    phase = "R4";
    liveTime = {8'h24, 8'h11, 8'h30, 8'h05, 8'h21, 8'h47, 8'h33, 8'h20};
    pulseSec();
    rdExpect(BASE + 2, 8'hC7, "R4 minutes keep spare");
    rdExpect(BASE + 4, 8'hBD, "R4 weekday");
    rdExpect(BASE + 1, 8'h33, "R4 seconds");

    // R5 read halt
    phase = "R5";
    wrByte(BASE + 0, 8'h60);
    liveTime = {8'h25, 8'h12, 8'h01, 8'h06, 8'h22, 8'h48, 8'h34, 8'h20};
    pulseSec();
    rdExpect(BASE + 1, 8'h33, "R5 frozen seconds");
    wrByte(BASE + 0, 8'h20);
    pulseSec();
    rdExpect(BASE + 1, 8'h34, "R4 refresh after release");

    // R6 write halt and load
    phase = "R6";
    wrByte(BASE + 0, 8'hA0);
    wrByte(BASE + 1, 8'h10);
    wrByte(BASE + 7, 8'h30);
    pulseSec();
    rdExpect(BASE + 1, 8'h10, "R6 no refresh under write halt");
    s0 = strobes;
    wrByte(BASE + 0, 8'h20);
    tick(); tick();
    chk(strobes - s0 == 1, "R6 single strobe", 64'(strobes - s0), 64'd1);

    // R7 write and refresh in one cycle
    phase = "R7";
    liveTime = {8'h26, 8'h03, 8'h15, 8'h02, 8'h09, 8'h05, 8'h00, 8'h20};
    secTick = 1;
    wrByte(BASE + 2, 8'h12);
    secTick = 0;
    rdExpect(BASE + 2, 8'h12, "R7 written byte wins");
    rdExpect(BASE + 3, 8'hC9, "R7 neighbour refreshed");

    // R8 oscillator stop
    phase = "R8";
    wrByte(BASE + 1, 8'h80);
    chk(oscStop == 1'b1, "R8 stop set", 64'(oscStop), 64'd1);
    wrByte(BASE + 1, 8'h00);
    chk(oscStop == 1'b0, "R8 stop clear", 64'(oscStop), 64'd0);

    // R9 frequency test
    phase = "R9";
    wrByte(BASE + 4, 8'h45);
    ceN = 0; oeN = 0; weN = 1; addr = AW'(BASE + 1);
    oscTick = 1;
    for (int i = 0; i < 80; i++) tick();
    oscTick = 0;
    idle();
    wrByte(BASE + 1, 8'h80);
    ceN = 0; oeN = 0; weN = 1; addr = AW'(BASE + 1);
    oscTick = 1;
    for (int i = 0; i < 40; i++) tick();
    oscTick = 0;
    idle();
    wrByte(BASE + 1, 8'h00);
    wrByte(BASE + 4, 8'h05);

    // R11 power fail
    phase = "R11";
    pwrFail = 1;
    wrByte(BASE + 7, 8'h00);
    wrByte(16'h100, 8'h55);
    ceN = 0; oeN = 0; weN = 1; addr = AW'(BASE + 7);
    tick();
    idle();
    pwrFail = 0;
    tick();
    rdExpect(BASE + 7, 8'h26, "R11 year kept");

    // R12 RAM pass-through
    phase = "R12";
    ramRdData = 8'h5A;
    rdExpect(32'h123, 8'h5A, "R12 ram read");
    wrByte(32'h124, 8'hA5);
    tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule